// File: doc/BRIEF.md
# Capture Slot Serial and TDM Output Formatter

This block takes six 24-bit capture slot values, produced elsewhere in a signal-processing core, and sends them off chip in a form that external converters or another processor can read. A 2-bit mode field and a separate enable bit choose what the output pins carry. One dedicated capture pin can carry a stereo stream. Three multifunction pins can carry a six-channel time-division frame with a bit clock and frame sync made inside the block, or an unchanged copy of a serial mux source, or nothing.

In stereo mode the block does not make its own clocks. It follows the bit clock and left/right clock of the incoming audio stream, which it oversamples through a two-stage synchronizer in the system clock domain. Capture slot 1 goes out in the left half of the frame and slot 2 in the right half. In TDM mode a divider makes the bit clock from the system clock. Each frame holds six 32-bit slots, and each slot holds 24 data bits followed by 8 zero bits. Both modes take a snapshot of their source values at the start of a frame, so a slot value never changes partway through a frame.

Top module: `cap_serial_out`

## Requirements
- R1: While reset is high and on the first cycle after it, cap_sdo, mf_data, mf_fs and mf_bclk are all low.
- R2: When mode_sel is 00, cap_sdo stays low. When mode_sel is 00 or 10 and mux_en is 0, mf_data, mf_fs and mf_bclk stay low.
- R3: When mode_sel is 00 or 10 and mux_en is 1, mf_data, mf_fs and mf_bclk equal mux_sd, mux_lrclk and mux_bclk as they were one clock cycle earlier.
- R4: When mode_sel is 10, cap_sdo carries a stereo stream. A channel starts at the first falling edge of in_bclk where in_lrclk differs from its value at the previous falling edge. in_lrclk low means left, which carries slot 1 (slot_data[47:24]); in_lrclk high means right, which carries slot 2 (slot_data[71:48]). The stream is MSB first, with one bit per in_bclk period, valid at the rising edge of in_bclk. The 24 data bits are followed by zeros until the next channel starts.
- R5: Both channels of a stereo frame use the slot 1 and slot 2 values present when the left channel starts. A change made later in that frame appears only in the next frame.
- R6: When mode_sel is 01, mf_bclk is the system clock divided by 2*BCLK_DIV, which is 4 with the default parameters. mf_data changes only on a falling mf_bclk edge. A frame holds slots 0 to 5 in order, each 32 bit periods long: 24 data bits MSB first, then 8 zero bits. Slot k is slot_data[24k+23:24k].
- R7: When mode_sel is 01, mf_fs is high for exactly the first bit period of each 192-bit frame, and it changes only on a falling mf_bclk edge.
- R8: A TDM frame sends the slot values present at its first bit. A change made during a frame appears in the next frame.
- R9: When mode_sel is 01, mux_en has no effect and cap_sdo stays low.
- R10: When mode_sel is 11, all four output pins stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Output mode: 00 idle, 01 TDM, 10 stereo, 11 off |
| mux_en | input | 1 | Routes the serial mux source to the multifunction pins in modes 00 and 10 |
| slot_data | input | 144 | Six 24-bit capture slots; slot k at bits 24k+23:24k |
| in_bclk | input | 1 | Bit clock of the input audio stream |
| in_lrclk | input | 1 | Left/right clock of the input audio stream (low = left) |
| mux_sd | input | 1 | Serial mux source data |
| mux_bclk | input | 1 | Serial mux source bit clock |
| mux_lrclk | input | 1 | Serial mux source frame clock |
| cap_sdo | output | 1 | Dedicated capture serial data pin |
| mf_data | output | 1 | Multifunction pin: TDM data or mux data |
| mf_fs | output | 1 | Multifunction pin: TDM frame sync or mux frame clock |
| mf_bclk | output | 1 | Multifunction pin: TDM bit clock or mux bit clock |

## Verification
In mode 10 with mux_en set, the stereo serializer drives cap_sdo while the pass-through path drives the multifunction pins, so both paths update in the same cycles. The bench provokes this by running a checked stereo frame in parallel with a stream of changing mux inputs. The scoreboard judges each stereo bit at the rising edge of in_bclk. Each mux bit is checked against the value driven one cycle earlier. A second overlap is a slot change that lands in the same frame as a snapshot. The bench rewrites the slot values partway through a frame, in both stereo and TDM modes, and expects the old values until the next frame starts.

// File: rtl/cap_fmt_pkg.sv
package cap_fmt_pkg;

  // Output mode codes; the encoding is seen at the top-level mode_sel port.
  typedef enum logic [1:0] {
    CM_IDLE   = 2'b00,
    CM_TDM    = 2'b01,
    CM_STEREO = 2'b10,
    CM_RSVD   = 2'b11
  } cap_mode_e;

  // One set of three multifunction pin values.
  typedef struct packed {
    logic data;
    logic fs;
    logic bclk;
  } pin_trio_t;

endpackage

// File: rtl/cap_tdm_gen.sv
module cap_tdm_gen
  import cap_fmt_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int BCLK_DIV  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] slot_bus,
  output pin_trio_t                     tdm_pins
);

  localparam int SIDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int POS_W  = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam int DIV_W  = (BCLK_DIV > 1) ? $clog2(BCLK_DIV) : 1;
  localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_SLOTS - 1);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(SLOT_W - 1);
  localparam logic [DIV_W-1:0]  LAST_DIV  = DIV_W'(BCLK_DIV - 1);
  localparam logic [POS_W:0]    DATA_BITS = (POS_W + 1)'(SAMPLE_W);

  typedef logic [SAMPLE_W-1:0] word_t;

  word_t live   [NUM_SLOTS];
  word_t shadow [NUM_SLOTS];

  logic [DIV_W-1:0]  div_cnt;
  logic              bclk_r;
  logic [SIDX_W-1:0] slot_cnt;
  logic [POS_W-1:0]  pos_cnt;
  logic              data_r;
  logic              fs_r;

  logic              fall_tick;
  logic [POS_W-1:0]  nxt_pos;
  logic [SIDX_W-1:0] nxt_slot;
  logic              frame_start;
  word_t             src_word;
  word_t             shifted;
  logic              nxt_bit;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
    assign live[g] = slot_bus[g*SAMPLE_W +: SAMPLE_W];
  end

  // Next bit position; the idle counter values make the first falling edge land on bit 0.
  always_comb begin
    fall_tick = (div_cnt == LAST_DIV) && bclk_r;
    if (pos_cnt == LAST_POS) begin
      nxt_pos  = '0;
      nxt_slot = (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
    end else begin
      nxt_pos  = pos_cnt + 1'b1;
      nxt_slot = slot_cnt;
    end
    frame_start = (nxt_slot == '0) && (nxt_pos == '0);
    src_word    = frame_start ? live[0] : shadow[nxt_slot];
    shifted     = src_word << nxt_pos;
    nxt_bit     = ({1'b0, nxt_pos} < DATA_BITS) ? shifted[SAMPLE_W-1] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      div_cnt  <= '0;
      bclk_r   <= 1'b0;
      slot_cnt <= LAST_SLOT;
      pos_cnt  <= LAST_POS;
      data_r   <= 1'b0;
      fs_r     <= 1'b0;
    end else if (div_cnt == LAST_DIV) begin
      div_cnt <= '0;
      bclk_r  <= ~bclk_r;
      if (bclk_r) begin
        slot_cnt <= nxt_slot;
        pos_cnt  <= nxt_pos;
        data_r   <= nxt_bit;
        fs_r     <= frame_start;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // Frame snapshot storage: written only at a frame start, no reset needed.
  always_ff @(posedge clk) begin
    if (en && fall_tick && frame_start) begin
      for (int i = 0; i < NUM_SLOTS; i++) shadow[i] <= live[i];
    end
  end

  assign tdm_pins = '{data: data_r, fs: fs_r, bclk: bclk_r};

endmodule

// File: rtl/cap_stereo_ser.sv
module cap_stereo_ser #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_in,
  input  logic                lr_in,
  input  logic [SAMPLE_W-1:0] left_word,
  input  logic [SAMPLE_W-1:0] right_word,
  output logic                sdo
);

  logic [2:0]          bclk_sync;
  logic [1:0]          lr_sync;
  logic                lr_last;
  logic [SAMPLE_W-1:0] shift_r;
  logic [SAMPLE_W-1:0] hold_right;
  logic                sdo_r;

  logic fall;
  logic lr_now;

  assign fall   = bclk_sync[2] & ~bclk_sync[1];
  assign lr_now = lr_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_sync <= 3'b111;
      lr_sync   <= 2'b11;
    end else begin
      bclk_sync <= {bclk_sync[1:0], bclk_in};
      lr_sync   <= {lr_sync[0], lr_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_last    <= 1'b1;
      shift_r    <= '0;
      hold_right <= '0;
      sdo_r      <= 1'b0;
    end else if (fall) begin
      lr_last <= lr_now;
      if (lr_now != lr_last) begin
        if (!lr_now) begin
          // Left channel starts a frame: snapshot both channels.
          sdo_r      <= left_word[SAMPLE_W-1];
          shift_r    <= left_word << 1;
          hold_right <= right_word;
        end else begin
          sdo_r   <= hold_right[SAMPLE_W-1];
          shift_r <= hold_right << 1;
        end
      end else begin
        sdo_r   <= shift_r[SAMPLE_W-1];
        shift_r <= shift_r << 1;
      end
    end
  end

  assign sdo = sdo_r;

endmodule

// File: rtl/cap_pin_route.sv
module cap_pin_route
  import cap_fmt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cap_mode_e mode,
  input  logic      mux_en,
  input  logic      stereo_sd,
  input  pin_trio_t tdm_pins,
  input  pin_trio_t mux_pins,
  output logic      cap_sdo,
  output pin_trio_t mf_pins
);

  logic      cap_nxt;
  pin_trio_t mf_nxt;

  always_comb begin
    cap_nxt = 1'b0;
    mf_nxt  = '0;
    unique case (mode)
      CM_IDLE: begin
        if (mux_en) mf_nxt = mux_pins;
      end
      CM_TDM: begin
        mf_nxt = tdm_pins;
      end
      CM_STEREO: begin
        cap_nxt = stereo_sd;
        if (mux_en) mf_nxt = mux_pins;
      end
      default: begin
        cap_nxt = 1'b0;
        mf_nxt  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_sdo <= 1'b0;
      mf_pins <= '0;
    end else begin
      cap_sdo <= cap_nxt;
      mf_pins <= mf_nxt;
    end
  end

endmodule

// File: rtl/cap_serial_out.sv
module cap_serial_out
  import cap_fmt_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_W    = 32,
  parameter int BCLK_DIV  = 2,
  parameter int LEFT_IDX  = 1,
  parameter int RIGHT_IDX = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    mode_sel,
  input  logic                          mux_en,
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] slot_data,
  input  logic                          in_bclk,
  input  logic                          in_lrclk,
  input  logic                          mux_sd,
  input  logic                          mux_bclk,
  input  logic                          mux_lrclk,
  output logic                          cap_sdo,
  output logic                          mf_data,
  output logic                          mf_fs,
  output logic                          mf_bclk
);

  cap_mode_e mode;
  pin_trio_t tdm_pins;
  pin_trio_t mux_pins;
  pin_trio_t mf_pins;
  logic      stereo_sd;

  assign mode     = cap_mode_e'(mode_sel);
  assign mux_pins = '{data: mux_sd, fs: mux_lrclk, bclk: mux_bclk};

  cap_tdm_gen #(
    .NUM_SLOTS (NUM_SLOTS),
    .SAMPLE_W  (SAMPLE_W),
    .SLOT_W    (SLOT_W),
    .BCLK_DIV  (BCLK_DIV)
  ) u_tdm (
    .clk      (clk),
    .rst      (rst),
    .en       (mode == CM_TDM),
    .slot_bus (slot_data),
    .tdm_pins (tdm_pins)
  );

  cap_stereo_ser #(
    .SAMPLE_W (SAMPLE_W)
  ) u_stereo (
    .clk        (clk),
    .rst        (rst),
    .bclk_in    (in_bclk),
    .lr_in      (in_lrclk),
    .left_word  (slot_data[LEFT_IDX*SAMPLE_W +: SAMPLE_W]),
    .right_word (slot_data[RIGHT_IDX*SAMPLE_W +: SAMPLE_W]),
    .sdo        (stereo_sd)
  );

  cap_pin_route u_route (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .mux_en    (mux_en),
    .stereo_sd (stereo_sd),
    .tdm_pins  (tdm_pins),
    .mux_pins  (mux_pins),
    .cap_sdo   (cap_sdo),
    .mf_pins   (mf_pins)
  );

  assign mf_data = mf_pins.data;
  assign mf_fs   = mf_pins.fs;
  assign mf_bclk = mf_pins.bclk;

endmodule

// File: rtl/cap_serial_out_chk.sv
module cap_serial_out_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_sel,
  input logic       mux_en,
  input logic       mux_sd,
  input logic       mux_bclk,
  input logic       mux_lrclk,
  input logic       cap_sdo,
  input logic       mf_data,
  input logic       mf_fs,
  input logic       mf_bclk
);

  // R2 and R9: the dedicated pin is silent outside stereo mode.
  p_cap_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 2'b10) |=> !cap_sdo);

  // R2: multifunction pins silent when the mux route is not enabled.
  p_mf_off_r2: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'b00 || mode_sel == 2'b10) && !mux_en)
      |=> !(mf_data || mf_fs || mf_bclk));

  // R3: pass-through follows the mux inputs one cycle later.
  p_mux_follow_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'b00 || mode_sel == 2'b10) && mux_en)
      |=> (mf_data == $past(mux_sd) && mf_fs == $past(mux_lrclk)
           && mf_bclk == $past(mux_bclk)));

  // R10: reserved code keeps every pin low.
  p_rsvd_off_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |=> !(cap_sdo || mf_data || mf_fs || mf_bclk));

  // R6: in steady TDM mode data moves only with a falling bit clock.
  p_data_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && $past(mode_sel, 2) == 2'b01
     && $past(mode_sel, 3) == 2'b01 && !$stable(mf_data)) |-> $fell(mf_bclk));

  // R7: frame sync moves only with a falling bit clock.
  p_fs_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && $past(mode_sel, 2) == 2'b01
     && $past(mode_sel, 3) == 2'b01 && !$stable(mf_fs)) |-> $fell(mf_bclk));

endmodule

bind cap_serial_out cap_serial_out_chk u_chk (.*);

// File: tb/sim_cap_serial_out.sv
module sim_cap_serial_out;
  localparam int NS = 6;
  localparam int SW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]       mode_sel  = 2'b00;
  logic             mux_en    = 1'b0;
  logic [NS*SW-1:0] slot_data = '0;
  logic             in_bclk   = 1'b1;
  logic             in_lrclk  = 1'b1;
  logic             mux_sd    = 1'b0;
  logic             mux_bclk  = 1'b0;
  logic             mux_lrclk = 1'b0;
  logic             cap_sdo, mf_data, mf_fs, mf_bclk;

  cap_serial_out u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .mux_en(mux_en),
    .slot_data(slot_data), .in_bclk(in_bclk), .in_lrclk(in_lrclk),
    .mux_sd(mux_sd), .mux_bclk(mux_bclk), .mux_lrclk(mux_lrclk),
    .cap_sdo(cap_sdo), .mf_data(mf_data), .mf_fs(mf_fs), .mf_bclk(mf_bclk)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic  d;
    logic  fs;
    string req;
  } exp_t;

  exp_t q2[$];
  exp_t qt[$];

  logic [23:0] va [NS];
  logic [23:0] vb [NS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic set_slot(input int i, input logic [23:0] v);
    slot_data[i*SW +: SW] = v;
  endtask

  // Stereo monitor: judge cap_sdo at every rising in_bclk with a pending expectation.
  always @(posedge in_bclk) begin : mon_stereo
    exp_t e;
    if (q2.size() > 0) begin
      e = q2.pop_front();
      check(cap_sdo === e.d, e.req, "cap_sdo", int'(cap_sdo), int'(e.d));
    end
  end

  // TDM monitor: locks on the first frame sync, then judges each rising mf_bclk.
  logic prev_b = 1'b0;
  bit   tsync = 1'b0;
  int   cyc = 0;
  always @(negedge clk) begin : mon_tdm
    exp_t e;
    cyc++;
    if (mode_sel != 2'b01) begin
      tsync = 1'b0;
    end else if (mf_bclk && !prev_b) begin
      if (tsync && qt.size() > 0)
        check(cyc == 4, "R6", "bclk period", cyc, 4);
      if (qt.size() > 0 && (tsync || mf_fs)) begin
        e = qt.pop_front();
        tsync = 1'b1;
        check(mf_data === e.d, e.req, "mf_data", int'(mf_data), int'(e.d));
        check(mf_fs === e.fs, "R7", "mf_fs", int'(mf_fs), int'(e.fs));
      end
      cyc = 0;
    end
    prev_b = mf_bclk;
  end

  // One stereo frame; optionally rewrites slots 1/2 during the left channel.
  task automatic stereo_frame(input logic [23:0] lv, input logic [23:0] rv,
                              input bit chk, input string req, input bit swap,
                              input logic [23:0] nl, input logic [23:0] nr);
    exp_t e;
    for (int ch = 0; ch < 2; ch++) begin
      for (int b = 0; b < 32; b++) begin
        if (b == 0) in_lrclk = (ch == 1);
        tick(2);
        in_bclk = 1'b0;
        if (swap && ch == 0 && b == 8) begin
          set_slot(1, nl);
          set_slot(2, nr);
        end
        tick(6);
        if (chk) begin
          e.d   = (b < 24) ? ((ch == 0) ? lv[23-b] : rv[23-b]) : 1'b0;
          e.fs  = 1'b0;
          e.req = (ch == 1 && swap) ? "R5" : req;
          q2.push_back(e);
        end
        in_bclk = 1'b1;
        tick(4);
      end
    end
  endtask

  // Drives changing mux inputs and checks the multifunction pins one cycle later.
  task automatic mux_run(input int n, input bit pass, input string req);
    logic d, f, b;
    for (int i = 0; i < n; i++) begin
      d = i[0]; b = i[1]; f = i[2] ^ i[0];
      mux_sd = d; mux_bclk = b; mux_lrclk = f;
      tick(1);
      if (pass) begin
        check(mf_data === d && mf_bclk === b && mf_fs === f, req, "mux trio",
              int'({mf_data, mf_fs, mf_bclk}), int'({d, f, b}));
      end else begin
        check({mf_data, mf_fs, mf_bclk} === 3'b000, req, "mf trio off",
              int'({mf_data, mf_fs, mf_bclk}), 0);
      end
    end
  endtask

  task automatic off_watch(input int n, input bit cap_chk, input bit mf_chk,
                           input string req);
    for (int i = 0; i < n; i++) begin
      tick(8);
      if (cap_chk) check(cap_sdo === 1'b0, req, "cap_sdo off", int'(cap_sdo), 0);
      if (mf_chk) check({mf_data, mf_fs, mf_bclk} === 3'b000, req, "mf off",
                        int'({mf_data, mf_fs, mf_bclk}), 0);
    end
  endtask

  task automatic push_tdm_frame(input bit use_b, input string req);
    exp_t e;
    logic [23:0] w;
    for (int s = 0; s < NS; s++) begin
      w = use_b ? vb[s] : va[s];
      for (int p = 0; p < 32; p++) begin
        e.d   = (p < 24) ? w[23-p] : 1'b0;
        e.fs  = (s == 0 && p == 0);
        e.req = req;
        qt.push_back(e);
      end
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin : main
    tick(1);
    // R1: outputs low during reset and right after it
    check({cap_sdo, mf_data, mf_fs, mf_bclk} === 4'b0000, "R1", "in reset",
          int'({cap_sdo, mf_data, mf_fs, mf_bclk}), 0);
    tick(4);
    rst = 1'b0;
    tick(1);
    check({cap_sdo, mf_data, mf_fs, mf_bclk} === 4'b0000, "R1", "after reset",
          int'({cap_sdo, mf_data, mf_fs, mf_bclk}), 0);

    set_slot(1, 24'hA5C3F1);
    set_slot(2, 24'h3C0F96);

    // R2: idle mode, enable clear, stereo clocks and mux inputs active
    mode_sel = 2'b00; mux_en = 1'b0;
    fork
      stereo_frame(24'h0, 24'h0, 1'b0, "R2", 1'b0, 24'h0, 24'h0);
      mux_run(40, 1'b0, "R2");
      off_watch(80, 1'b1, 1'b0, "R2");
    join

    // R3: idle mode with the mux route enabled
    mux_en = 1'b1;
    mux_run(40, 1'b1, "R3");

    // R4: stereo mode, plain frames, multifunction pins held low
    mode_sel = 2'b10; mux_en = 1'b0;
    fork
      stereo_frame(24'hA5C3F1, 24'h3C0F96, 1'b1, "R4", 1'b0, 24'h0, 24'h0);
      off_watch(80, 1'b0, 1'b1, "R2");
    join
    // R5: slots rewritten during the left channel
    stereo_frame(24'hA5C3F1, 24'h3C0F96, 1'b1, "R4", 1'b1, 24'h800001, 24'hFFFFFF);
    stereo_frame(24'h800001, 24'hFFFFFF, 1'b1, "R5", 1'b0, 24'h0, 24'h0);

    // R3 with R4: both paths active in the same cycles
    mux_en = 1'b1;
    set_slot(1, 24'h13579B);
    set_slot(2, 24'h2468AC);
    fork
      stereo_frame(24'h13579B, 24'h2468AC, 1'b1, "R4", 1'b0, 24'h0, 24'h0);
      mux_run(300, 1'b1, "R3");
    join
    check(q2.size() == 0, "R4", "stereo queue drained", q2.size(), 0);

    // R6, R7, R8, R9: TDM with mux_en set (ignored) and a mid-frame slot change
    for (int s = 0; s < NS; s++) begin
      va[s] = 24'h100001 * (s + 1) ^ 24'h5A5A5A;
      vb[s] = ~va[s] ^ (24'h000F00 << s);
      set_slot(s, va[s]);
    end
    push_tdm_frame(1'b0, "R6");
    push_tdm_frame(1'b1, "R8");
    mux_en = 1'b1;
    mode_sel = 2'b01;
    fork
      begin
        tick(200);
        for (int s = 0; s < NS; s++) set_slot(s, vb[s]);
      end
      begin
        for (int k = 0; k < 4000 && qt.size() > 0; k++) begin
          tick(1);
          if (k % 100 == 50)
            check(cap_sdo === 1'b0, "R9", "cap_sdo in TDM", int'(cap_sdo), 0);
        end
      end
    join
    check(qt.size() == 0, "R6", "tdm queue drained", qt.size(), 0);

    // R10: reserved code with every source active
    mode_sel = 2'b11; mux_en = 1'b1;
    tick(2);
    fork
      stereo_frame(24'h0, 24'h0, 1'b0, "R10", 1'b0, 24'h0, 24'h0);
      mux_run(40, 1'b0, "R10");
      off_watch(90, 1'b1, 1'b1, "R10");
    join

    finished = 1;
    summary();
    $finish;
  end

endmodule